// File: doc/BRIEF.md
# Serial-Loaded Cartridge Bank Controller

This block translates CPU and PPU addresses into bank-extended memory addresses for a game cartridge. Its configuration registers are not written in parallel. Software programs them one bit at a time: five CPU writes anywhere in $8000-$FFFF each present one data bit. The fifth write commits the collected value to one of four registers, and the address of that write picks the register. A write with data bit 7 set aborts a partial sequence at any point.

The block decodes three things from its registers. The first is the 16 KB PRG-ROM window layout, which has three switching schemes. The second is the 4 KB CHR window layout. The third is the nametable mirroring arrangement. It also drives a select for the 8 KB PRG-RAM at $6000-$7FFF. For a board with no CHR-ROM, it passes PPU pattern accesses straight through to an 8 KB CHR-RAM and enables writes to it. The memory arrays themselves are outside the block, which supplies only addresses and selects.

Top module: `cart_bank_ctl`

## Requirements
- R1: A CPU write with `cpu_addr[15]`=1 and `cpu_wdata[7]`=1 empties the serial collector: the next write starts a new five-write group. The same write also sets control bits 3:2 to 2'b11 and leaves the other control bits unchanged.
- R2: Each other write with `cpu_addr[15]`=1 contributes `cpu_wdata[0]`, first write to value bit 0. The fifth such write commits the 5-bit value and restarts the count.
- R3: The committing write's `cpu_addr[14:13]` picks the destination: 0 control, 1 CHR register A, 2 CHR register B, 3 PRG register.
- R4: `mirror_mode` equals control bits 1:0: 0 single-screen low, 1 single-screen high, 2 vertical, 3 horizontal.
- R5: In PRG mode 0 or 1 (control bits 3:2), `prg_rom_addr` = {PRG bank with bit 0 replaced by `cpu_addr[14]`, `cpu_addr[13:0]`}.
- R6: In PRG mode 2, $8000-$BFFF uses bank 0 and $C000-$FFFF uses the PRG bank. In PRG mode 3, $8000-$BFFF uses the PRG bank and $C000-$FFFF uses bank PRG_BANKS-1.
- R7: The PRG register holds the bank number in bits 3:0 and a RAM enable in bit 4. `prg_ram_sel` is 1 exactly when `cpu_addr` lies in $6000-$7FFF and that enable is 1.
- R8: When control bit 4 is 1, CHR registers A and B load the low and high 4 KB windows independently. When control bit 4 is 0, a commit to register A with value v loads the low window with v with bit 0 cleared and the high window with v with bit 0 set. In that mode a commit to register B changes nothing. `chr_addr` = {window bank selected by `ppu_addr[12]`, `ppu_addr[11:0]`}.
- R9: With CHR_ROM_PRESENT=0, `chr_addr` = `ppu_addr` zero-extended and `chr_ram_we` follows `ppu_wr`. With CHR_ROM_PRESENT=1, `chr_ram_we` stays 0.
- R10: Synchronous reset leaves control at 5'b01100 and all other registers and the collector at zero.
- R11: CPU writes with `cpu_addr[15]`=0 leave the collector and all registers untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 13 | PPU pattern address ($0000-$1FFF) |
| ppu_wr | input | 1 | PPU write strobe |
| prg_rom_addr | output | 18 | Bank-extended PRG-ROM address |
| prg_ram_sel | output | 1 | PRG-RAM select |
| chr_addr | output | 17 | Bank-extended CHR address |
| chr_ram_we | output | 1 | CHR-RAM write enable |
| mirror_mode | output | 2 | Nametable arrangement code |

## Verification
The bench aborts sequences partway through with bit-7 writes. A design that failed to clear the count would commit a value one or more bits out of alignment, and the wrong register or window would appear. It checks the high window in each PRG mode, where fixing bank 0 in place of the last bank, or failing to force the low bit in 32 KB mode, shows up as a wrong upper address. It writes CHR register B while 8 KB mode is active, which catches a design that lets that write through. It also drops writes to $6000 into the middle of a sequence, which catches a collector that counts every CPU write. Randomized groups with interleaved aborts are compared against an independent model after every commit.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    localparam int SER_W       = 5;
    localparam int CNT_W       = 3;
    localparam int PRG_BANK_W  = 4;
    localparam int CHR_BANK_W  = 5;
    localparam int PRG_OFS_W   = 14;
    localparam int CHR_OFS_W   = 12;
    localparam int PRG_AW      = PRG_BANK_W + PRG_OFS_W;
    localparam int CHR_AW      = CHR_BANK_W + CHR_OFS_W;
    localparam int CHR_RAM_AW  = CHR_OFS_W + 1;

    typedef enum logic [1:0] {
        MIR_ONE_LO = 2'd0,
        MIR_ONE_HI = 2'd1,
        MIR_VERT   = 2'd2,
        MIR_HORZ   = 2'd3
    } mirror_e;

    typedef enum logic [1:0] {
        DST_CTRL = 2'd0,
        DST_CHRA = 2'd1,
        DST_CHRB = 2'd2,
        DST_PRG  = 2'd3
    } dest_e;

    typedef struct packed {
        logic       chr_split;
        logic [1:0] prg_mode;
        mirror_e    mirror;
    } ctrl_t;

    typedef struct packed {
        logic                  ram_en;
        logic [PRG_BANK_W-1:0] bank;
    } prgreg_t;

    typedef struct packed {
        logic             valid;
        dest_e            dest;
        logic [SER_W-1:0] data;
    } commit_t;

    localparam ctrl_t CTRL_RESET = '{chr_split: 1'b0, prg_mode: 2'b11, mirror: MIR_ONE_LO};

    function automatic logic [PRG_BANK_W-1:0] prg_bank_pick(
        input logic [1:0]            mode,
        input logic [PRG_BANK_W-1:0] sel,
        input logic                  upper,
        input logic [PRG_BANK_W-1:0] last
    );
        logic [PRG_BANK_W-1:0] b;
        unique case (mode)
            2'd0, 2'd1: b = {sel[PRG_BANK_W-1:1], upper};
            2'd2:       b = upper ? sel : '0;
            default:    b = upper ? last : sel;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/cbc_serial_loader.sv
module cbc_serial_loader
    import cbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       dest_sel,
    input  logic             din_bit,
    input  logic             din_abort,
    output commit_t          commit,
    output logic             abort_hit,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SER_W - 1);

    logic [SER_W-2:0] sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last   = (cnt_q == LAST_CNT);
    assign abort_hit = wr_en & din_abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (wr_en) begin
            if (din_abort || at_last) begin
                sh_q  <= '0;
                cnt_q <= '0;
            end else begin
                sh_q  <= {din_bit, sh_q[SER_W-2:1]};
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        commit.valid = wr_en & ~din_abort & at_last;
        commit.dest  = dest_e'(dest_sel);
        commit.data  = {din_bit, sh_q};
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/cbc_regfile.sv
module cbc_regfile
    import cbc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  commit_t               commit,
    input  logic                  abort_hit,
    output ctrl_t                 ctrl,
    output logic [CHR_BANK_W-1:0] chr_lo,
    output logic [CHR_BANK_W-1:0] chr_hi,
    output prgreg_t               prg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= CTRL_RESET;
            chr_lo <= '0;
            chr_hi <= '0;
            prg    <= '0;
        end else if (abort_hit) begin
            ctrl.prg_mode <= 2'b11;
        end else if (commit.valid) begin
            unique case (commit.dest)
                DST_CTRL: ctrl <= ctrl_t'(commit.data);
                DST_CHRA: begin
                    if (ctrl.chr_split) begin
                        chr_lo <= commit.data;
                    end else begin
                        chr_lo <= {commit.data[SER_W-1:1], 1'b0};
                        chr_hi <= {commit.data[SER_W-1:1], 1'b1};
                    end
                end
                DST_CHRB: begin
                    if (ctrl.chr_split) chr_hi <= commit.data;
                end
                default:  prg <= prgreg_t'(commit.data);
            endcase
        end
    end
endmodule

// File: rtl/cbc_prg_map.sv
module cbc_prg_map
    import cbc_pkg::*;
#(
    parameter int PRG_BANKS = 16
) (
    input  logic [15:0]       cpu_addr,
    input  ctrl_t             ctrl,
    input  prgreg_t           prg,
    output logic [PRG_AW-1:0] prg_rom_addr,
    output logic              prg_ram_sel
);
    localparam logic [PRG_BANK_W-1:0] LAST_BANK = PRG_BANK_W'(PRG_BANKS - 1);

    logic [PRG_BANK_W-1:0] bank;

    always_comb begin
        bank         = prg_bank_pick(ctrl.prg_mode, prg.bank, cpu_addr[14], LAST_BANK);
        prg_rom_addr = {bank, cpu_addr[PRG_OFS_W-1:0]};
        prg_ram_sel  = (cpu_addr[15:13] == 3'b011) & prg.ram_en;
    end
endmodule

// File: rtl/cbc_chr_map.sv
module cbc_chr_map
    import cbc_pkg::*;
#(
    parameter bit CHR_ROM_PRESENT = 1'b1
) (
    input  logic [CHR_RAM_AW-1:0] ppu_addr,
    input  logic                  ppu_wr,
    input  logic [CHR_BANK_W-1:0] chr_lo,
    input  logic [CHR_BANK_W-1:0] chr_hi,
    output logic [CHR_AW-1:0]     chr_addr,
    output logic                  chr_ram_we
);
    generate
        if (CHR_ROM_PRESENT) begin : g_rom
            logic unused_wr;
            assign unused_wr  = ppu_wr;
            assign chr_addr   = {(ppu_addr[CHR_OFS_W] ? chr_hi : chr_lo), ppu_addr[CHR_OFS_W-1:0]};
            assign chr_ram_we = 1'b0;
        end else begin : g_ram
            logic unused_banks;
            assign unused_banks = ^{chr_lo, chr_hi};
            assign chr_addr   = CHR_AW'(ppu_addr);
            assign chr_ram_we = ppu_wr;
        end
    endgenerate
endmodule

// File: rtl/cart_bank_ctl.sv
module cart_bank_ctl
    import cbc_pkg::*;
#(
    parameter int PRG_BANKS       = 16,
    parameter bit CHR_ROM_PRESENT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_wr,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic [12:0] ppu_addr,
    input  logic        ppu_wr,
    output logic [17:0] prg_rom_addr,
    output logic        prg_ram_sel,
    output logic [16:0] chr_addr,
    output logic        chr_ram_we,
    output logic [1:0]  mirror_mode
);
    commit_t               commit;
    logic                  abort_hit;
    logic [CNT_W-1:0]      ser_cnt;
    ctrl_t                 ctrl;
    logic [CHR_BANK_W-1:0] chr_lo, chr_hi;
    prgreg_t               prg;
    logic                  unused_data;

    assign unused_data = ^cpu_wdata[6:1];

    cbc_serial_loader u_ser (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cpu_wr & cpu_addr[15]),
        .dest_sel  (cpu_addr[14:13]),
        .din_bit   (cpu_wdata[0]),
        .din_abort (cpu_wdata[7]),
        .commit    (commit),
        .abort_hit (abort_hit),
        .cnt       (ser_cnt)
    );

    cbc_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .abort_hit (abort_hit),
        .ctrl      (ctrl),
        .chr_lo    (chr_lo),
        .chr_hi    (chr_hi),
        .prg       (prg)
    );

    cbc_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .cpu_addr     (cpu_addr),
        .ctrl         (ctrl),
        .prg          (prg),
        .prg_rom_addr (prg_rom_addr),
        .prg_ram_sel  (prg_ram_sel)
    );

    cbc_chr_map #(.CHR_ROM_PRESENT(CHR_ROM_PRESENT)) u_chr (
        .ppu_addr   (ppu_addr),
        .ppu_wr     (ppu_wr),
        .chr_lo     (chr_lo),
        .chr_hi     (chr_hi),
        .chr_addr   (chr_addr),
        .chr_ram_we (chr_ram_we)
    );

    assign mirror_mode = ctrl.mirror;
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
    parameter int PRG_BANKS       = 16,
    parameter bit CHR_ROM_PRESENT = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        cpu_wr,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic [2:0]  ser_cnt,
    input logic [4:0]  ctrl_bits,
    input logic [17:0] prg_rom_addr,
    input logic        ppu_wr,
    input logic        chr_ram_we
);
    localparam logic [3:0] LAST = 4'(PRG_BANKS - 1);

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst) ser_cnt <= 3'd4);

    p_fifth_wraps_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15] && !cpu_wdata[7] && ser_cnt == 3'd4) |=> ser_cnt == 3'd0);

    p_abort_write_r1: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15] && cpu_wdata[7]) |=> (ser_cnt == 3'd0 && ctrl_bits[3:2] == 2'b11));

    p_fixed_last_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_bits[3:2] == 2'b11 && cpu_addr[15:14] == 2'b11) |-> prg_rom_addr[17:14] == LAST);

    p_low_write_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_addr[15]) |=> ($stable(ser_cnt) && $stable(ctrl_bits)));

    p_chr_we_r9: assert property (@(posedge clk) disable iff (rst)
        chr_ram_we == (ppu_wr && !CHR_ROM_PRESENT));
endmodule

bind cart_bank_ctl cbc_checker #(.PRG_BANKS(PRG_BANKS), .CHR_ROM_PRESENT(CHR_ROM_PRESENT)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_wr       (cpu_wr),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .ser_cnt      (ser_cnt),
    .ctrl_bits    (ctrl),
    .prg_rom_addr (prg_rom_addr),
    .ppu_wr       (ppu_wr),
    .chr_ram_we   (chr_ram_we)
);

// File: tb/tb_cart_bank_ctl.sv
module tb_cart_bank_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [12:0] ppu_addr = '0;
    logic        ppu_wr = 1'b0;
    logic [17:0] prg_rom_addr;
    logic        prg_ram_sel;
    logic [16:0] chr_addr, chr_addr_n;
    logic        chr_ram_we, chr_ram_we_n;
    logic [1:0]  mirror_mode, mirror_n;
    logic [17:0] prg_n;
    logic        ramsel_n;

    always #2 clk = ~clk;

    cart_bank_ctl dut (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .ppu_addr(ppu_addr), .ppu_wr(ppu_wr), .prg_rom_addr(prg_rom_addr),
        .prg_ram_sel(prg_ram_sel), .chr_addr(chr_addr), .chr_ram_we(chr_ram_we),
        .mirror_mode(mirror_mode));

    cart_bank_ctl #(.CHR_ROM_PRESENT(1'b0)) dut_ram (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .ppu_addr(ppu_addr), .ppu_wr(ppu_wr), .prg_rom_addr(prg_n),
        .prg_ram_sel(ramsel_n), .chr_addr(chr_addr_n), .chr_ram_we(chr_ram_we_n),
        .mirror_mode(mirror_n));

    typedef struct {
        int          sel;
        logic [17:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // independent reference model
    logic [4:0] m_ctrl = 5'b01100, m_chra = 0, m_chrb = 0, m_prg = 0, m_acc = 0;
    int         m_cnt = 0;

    function automatic logic [3:0] exp_bank(logic [15:0] a);
        logic [3:0] s = m_prg[3:0];
        case (m_ctrl[3:2])
            2'd2:    return a[14] ? s : 4'd0;
            2'd3:    return a[14] ? 4'd15 : s;
            default: return (s & 4'hE) + {3'd0, a[14]};
        endcase
    endfunction

    task automatic m_write(logic [15:0] a, logic [7:0] d);
        if (!a[15]) return;
        if (d[7]) begin
            m_cnt = 0; m_acc = 0; m_ctrl = m_ctrl | 5'b01100;
            return;
        end
        m_acc[m_cnt] = d[0];
        if (m_cnt == 4) begin
            case (a[14:13])
                2'd0: m_ctrl = m_acc;
                2'd1: if (m_ctrl[4]) m_chra = m_acc;
                      else begin m_chra = m_acc & 5'h1E; m_chrb = m_chra + 5'd1; end
                2'd2: if (m_ctrl[4]) m_chrb = m_acc;
                default: m_prg = m_acc;
            endcase
            m_cnt = 0; m_acc = 0;
        end else m_cnt++;
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        ppu_wr = 0; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
        m_write(a, d);
        @(negedge clk);
        cpu_wr = 0;
    endtask

    task automatic load(logic [15:0] a, logic [4:0] v);
        for (int i = 0; i < 5; i++) wr(a, {7'd0, v[i]});
    endtask

    // sel: 0 prg addr, 1 ram sel, 2 mirror, 3 chr addr, 4 chr we, 5 ram-variant chr addr, 6 ram-variant we
    task automatic probe(int sel, logic [15:0] ca, logic [12:0] pa, logic pw, logic [17:0] e, string tag);
        @(negedge clk);
        cpu_wr = 0; cpu_addr = ca; ppu_addr = pa; ppu_wr = pw;
        q.push_back('{sel: sel, exp: e, tag: tag});
    endtask

    task automatic check_all(string tag);
        logic [15:0] a;
        logic [12:0] p;
        a = 16'h8000 | 16'($urandom_range(0, 16'h3FFF));
        probe(0, a, 0, 0, {exp_bank(a), a[13:0]}, {tag, "/R5/R6 low window"});
        a = 16'hC000 | 16'($urandom_range(0, 16'h3FFF));
        probe(0, a, 0, 0, {exp_bank(a), a[13:0]}, {tag, "/R5/R6 high window"});
        probe(1, 16'h6000 | 16'($urandom_range(0, 16'h1FFF)), 0, 0, {17'd0, m_prg[4]}, {tag, "/R7 ram in range"});
        probe(1, 16'h8000, 0, 0, 18'd0, {tag, "/R7 ram out of range"});
        probe(2, 16'h0, 0, 0, {16'd0, m_ctrl[1:0]}, {tag, "/R4 mirror"});
        p = 13'($urandom_range(0, 12'hFFF));
        probe(3, 0, p, 0, {1'b0, m_chra, p[11:0]}, {tag, "/R8 chr low"});
        p = 13'h1000 | 13'($urandom_range(0, 12'hFFF));
        probe(3, 0, p, 0, {1'b0, m_chrb, p[11:0]}, {tag, "/R8 chr high"});
    endtask

    // monitor: pops expected items and compares against outputs
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [17:0] act;
                it = q.pop_front();
                case (it.sel)
                    0: act = prg_rom_addr;
                    1: act = {17'd0, prg_ram_sel};
                    2: act = {16'd0, mirror_mode};
                    3: act = {1'b0, chr_addr};
                    4: act = {17'd0, chr_ram_we};
                    5: act = {1'b0, chr_addr_n};
                    default: act = {17'd0, chr_ram_we_n};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        check_all("R10 reset");

        load(16'h8000, 5'b01010);            // split=0, mode 2, vertical
        load(16'hE000, 5'b10101);            // ram on, bank 5
        check_all("R6 mode2");

        load(16'h9ABC, 5'b11111);            // split=1, mode 3, horizontal
        check_all("R6 mode3");

        load(16'h8000, 5'b00001);            // mode 0, single high
        check_all("R5 mode0");
        load(16'h8000, 5'b00101);            // mode 1
        check_all("R5 mode1");

        load(16'hA000, 5'd7);                // 8KB CHR: 6/7
        load(16'hC000, 5'd20);               // must be ignored
        check_all("R8 paired");

        load(16'h8000, 5'b10000);
        load(16'hBFFF, 5'd3);
        load(16'hDFFF, 5'd20);
        check_all("R8 split R3");

        wr(16'hE000, 8'h01); wr(16'hE000, 8'h00);
        wr(16'hFFFF, 8'h80);                 // abort mid-group
        check_all("R1 after abort");
        load(16'hE000, 5'b01001);
        check_all("R1 R2 post-abort group");

        wr(16'hE000, 8'h01); wr(16'hE000, 8'h01);
        wr(16'h6000, 8'h00); wr(16'h2000, 8'h81);   // not in serial range
        wr(16'hE000, 8'h00); wr(16'hE000, 8'h01); wr(16'hE000, 8'h00);
        check_all("R11 R2 low-page writes");

        probe(4, 0, 13'h0123, 1, 18'd0, "R9 rom board drops write");
        probe(6, 0, 13'h1ABC, 1, 18'd1, "R9 ram board write enable");
        probe(5, 0, 13'h1ABC, 1, 18'h01ABC, "R9 ram board address");
        probe(6, 0, 13'h0011, 0, 18'd0, "R9 ram board idle");

        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = 16'h8000 | 16'($urandom);
            d = 8'($urandom);
            if ($urandom_range(0, 7) != 0) d[7] = 0;
            wr(a, d);
            if (m_cnt == 0) check_all("R3 random");
        end

        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule